// File: doc/BRIEF.md
# Idle-Output Watchdog with Gain Backoff

This block supervises the switching output of a dynamic sensor front end. It counts clock cycles since the last output transition. When the output stays idle for a full observation window of 2^IDLE_BITS cycles, it issues a one-cycle system reset. That reset presets the amplifier gain code to zero and the 6-bit fine-gain DAC code to its midscale value (binary 100000), and it raises a hold flag. The hold freezes the output for the whole new self-calibration run. The calibration engine sits outside this block and reports completion on a done input, which drops the hold and opens a fresh observation window.

A second supervisor counts output transitions in which neither a maximum nor a minimum peak was found. On the sixteenth such transition in a row it lowers the gain code by one, saturating at zero, and does nothing else. Finding a peak restarts the run.

The front end's own gain logic can still raise the gain code through a step input. A backoff decrement takes precedence over such a step, and a watchdog preset takes precedence over both.

Top module: `swdg_gain_ctrl`

## Requirements
- R1: While `rst` is high and on the clock after it falls, `sys_rst_o` is 0, `out_hold_o` is 1, `pga_o` is 0 and `gain_dac_o` is 6'b100000 (32).
- R2: With `out_hold_o` low, 2^IDLE_BITS consecutive rising edges that carry no `out_edge_i` raise `sys_rst_o` for exactly one cycle, on the last of those edges.
- R3: An `out_edge_i` sampled while `out_hold_o` is low restarts the idle window, so the next reset comes 2^IDLE_BITS edges after that transition.
- R4: On the edge that raises `sys_rst_o`, `pga_o` becomes 0, `gain_dac_o` becomes 32 and `out_hold_o` becomes 1.
- R5: `out_hold_o` stays high until a `cal_done_i` pulse. While it is high the idle window does not advance and transitions do not count toward backoff.
- R6: With `out_hold_o` low, the 16th consecutive `out_edge_i` without a peak flag lowers `pga_o` by one and restarts the count.
- R7: A high `peak_max_i` or `peak_min_i`, with or without a transition in the same cycle, resets the peakless-transition count to zero.
- R8: A backoff decrement at `pga_o` = 0 leaves it at 0.
- R9: `gain_up_i` raises `pga_o` by one per cycle, saturating at 2^PGA_W-1. It works while held. A backoff decrement in the same cycle overrides the step.
- R10: A backoff decrement changes only `pga_o`: `gain_dac_o` is unchanged and no `sys_rst_o` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| out_edge_i | input | 1 | One-cycle pulse per output transition |
| peak_max_i | input | 1 | A valid maximum was found this cycle |
| peak_min_i | input | 1 | A valid minimum was found this cycle |
| gain_up_i | input | 1 | Step request to raise the gain code |
| cal_done_i | input | 1 | Self-calibration finished; releases the hold |
| sys_rst_o | output | 1 | One-cycle re-initialization pulse |
| out_hold_o | output | 1 | Keep the output at its previous level |
| pga_o | output | PGA_W | Amplifier gain code |
| gain_dac_o | output | DAC_W | Fine-gain DAC code |

## Verification
The bench lands on the exact edge that closes the idle window, one edge short of it, and the edge after it. A counter that is off by one, or a reset pulse wider than one cycle, shows up there. It sends transitions and gain steps while the hold is active, so a design that lets held transitions count would lower the gain, and one that keeps the idle window running during calibration would reset again. It also drives the 15th and 16th peakless transitions, a lone peak flag in the middle of a run, a decrement at zero, and a decrement in the same cycle as a gain step. These catch a premature backoff, a peak that fails to restart the count, a code that wraps to the maximum, and the wrong priority between the two requests.

// File: rtl/swdg_pkg.sv
package swdg_pkg;

  // Update selected for the gain registers on a given clock
  typedef enum logic [1:0] {
    OP_KEEP   = 2'd0,
    OP_PRESET = 2'd1,
    OP_DEC    = 2'd2,
    OP_INC    = 2'd3
  } gain_op_e;

endpackage

// File: rtl/swdg_idle_timer.sv
module swdg_idle_timer #(
  parameter int IDLE_BITS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic edge_i,
  output logic expire_o,
  output logic fire_o
);

  logic [IDLE_BITS-1:0] idle_cnt;

  // Last cycle of the window with no transition arriving
  assign expire_o = !hold_i && !edge_i && (idle_cnt == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      fire_o   <= 1'b0;
    end else begin
      fire_o <= expire_o;
      if (hold_i || edge_i || expire_o) begin
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !fire_o);                                        // R2
  AST_EDGE_RELOADS: assert property (@(posedge clk) disable iff (rst)
    (edge_i && !hold_i) |=> !fire_o);                           // R3
  AST_HELD_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> !fire_o);                                        // R5

endmodule

// File: rtl/swdg_backoff_counter.sv
module swdg_backoff_counter #(
  parameter int EVT_LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic expire_i,
  input  logic edge_i,
  input  logic peak_i,
  output logic dec_o
);

  localparam int EVT_W = $clog2(EVT_LIMIT);
  localparam logic [EVT_W-1:0] LAST = EVT_W'(EVT_LIMIT - 1);

  logic [EVT_W-1:0] evt_cnt;

  assign dec_o = !hold_i && edge_i && !peak_i && (evt_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || expire_i) begin
      evt_cnt <= '0;
    end else if (!hold_i) begin
      if (peak_i || dec_o) begin
        evt_cnt <= '0;
      end else if (edge_i) begin
        evt_cnt <= evt_cnt + 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    evt_cnt <= LAST);                                           // R6
  AST_PEAK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (peak_i && !hold_i) |=> (evt_cnt == '0));                   // R7
  AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !expire_i) |=> $stable(evt_cnt));                // R5

endmodule

// File: rtl/swdg_gain_regs.sv
module swdg_gain_regs
  import swdg_pkg::*;
#(
  parameter int PGA_W = 4,
  parameter int DAC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  gain_op_e         op_i,
  output logic [PGA_W-1:0] pga_o,
  output logic [DAC_W-1:0] dac_o
);

  localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1) << (DAC_W - 1);
  localparam logic [PGA_W-1:0] PGA_ONE = PGA_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pga_o <= '0;
      dac_o <= DAC_MID;
    end else begin
      unique case (op_i)
        OP_PRESET: begin
          pga_o <= '0;
          dac_o <= DAC_MID;
        end
        OP_DEC: if (pga_o != '0) pga_o <= pga_o - PGA_ONE;
        OP_INC: if (pga_o != '1) pga_o <= pga_o + PGA_ONE;
        default: ;
      endcase
    end
  end

  AST_PRESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PRESET) |=> (pga_o == '0 && dac_o == DAC_MID)); // R4
  AST_DEC_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_DEC && pga_o == '0) |=> (pga_o == '0));         // R8
  AST_INC_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_INC && pga_o == '1) |=> (pga_o == '1));         // R9
  AST_DAC_STABLE: assert property (@(posedge clk) disable iff (rst)
    (op_i != OP_PRESET) |=> $stable(dac_o));                    // R10

endmodule

// File: rtl/swdg_gain_ctrl.sv
module swdg_gain_ctrl
  import swdg_pkg::*;
#(
  parameter int IDLE_BITS = 20,
  parameter int EVT_LIMIT = 16,
  parameter int PGA_W     = 4,
  parameter int DAC_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             out_edge_i,
  input  logic             peak_max_i,
  input  logic             peak_min_i,
  input  logic             gain_up_i,
  input  logic             cal_done_i,
  output logic             sys_rst_o,
  output logic             out_hold_o,
  output logic [PGA_W-1:0] pga_o,
  output logic [DAC_W-1:0] gain_dac_o
);

  logic     expire;
  logic     dec_req;
  logic     peak_any;
  gain_op_e gain_op;

  assign peak_any = peak_max_i | peak_min_i;

  swdg_idle_timer #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .hold_i   (out_hold_o),
    .edge_i   (out_edge_i),
    .expire_o (expire),
    .fire_o   (sys_rst_o)
  );

  swdg_backoff_counter #(.EVT_LIMIT(EVT_LIMIT)) u_backoff (
    .clk      (clk),
    .rst      (rst),
    .hold_i   (out_hold_o),
    .expire_i (expire),
    .edge_i   (out_edge_i),
    .peak_i   (peak_any),
    .dec_o    (dec_req)
  );

  // Priority: watchdog preset, then backoff, then gain step
  always_comb begin
    if (expire)         gain_op = OP_PRESET;
    else if (dec_req)   gain_op = OP_DEC;
    else if (gain_up_i) gain_op = OP_INC;
    else                gain_op = OP_KEEP;
  end

  swdg_gain_regs #(.PGA_W(PGA_W), .DAC_W(DAC_W)) u_gain (
    .clk   (clk),
    .rst   (rst),
    .op_i  (gain_op),
    .pga_o (pga_o),
    .dac_o (gain_dac_o)
  );

  always_ff @(posedge clk) begin
    if (rst || expire) begin
      out_hold_o <= 1'b1;
    end else if (cal_done_i) begin
      out_hold_o <= 1'b0;
    end
  end

  AST_RST_SETS_HOLD: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> out_hold_o);                                  // R4
  AST_RST_PRESETS_GAIN: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> (pga_o == '0));                               // R4
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    (out_hold_o && !cal_done_i) |=> out_hold_o);                // R5

endmodule

// File: tb/tb_swdg_gain_ctrl.sv
module tb_swdg_gain_ctrl;

  localparam int IDLE_BITS = 6;
  localparam int WIN       = 1 << IDLE_BITS;
  localparam int PGA_W     = 4;
  localparam int DAC_W     = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic out_edge_i = 1'b0, peak_max_i = 1'b0, peak_min_i = 1'b0;
  logic gain_up_i = 1'b0, cal_done_i = 1'b0;
  logic sys_rst_o, out_hold_o;
  logic [PGA_W-1:0] pga_o;
  logic [DAC_W-1:0] gain_dac_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  swdg_gain_ctrl #(.IDLE_BITS(IDLE_BITS), .EVT_LIMIT(16), .PGA_W(PGA_W),
                   .DAC_W(DAC_W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(input logic pmax, input logic pmin, input logic gup);
    out_edge_i = 1'b1; peak_max_i = pmax; peak_min_i = pmin; gain_up_i = gup;
    step();
    out_edge_i = 1'b0; peak_max_i = 1'b0; peak_min_i = 1'b0; gain_up_i = 1'b0;
    step();
  endtask

  task automatic release_hold();
    cal_done_i = 1'b1; step(); cal_done_i = 1'b0;
    chk("R5 hold released", int'(out_hold_o), 0);
  endtask

  task automatic raise_gain(input int n);
    gain_up_i = 1'b1;
    repeat (n) step();
    gain_up_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; repeat (3) step(); rst = 1'b0; step();
    chk("R1 sys_rst", int'(sys_rst_o), 0);
    chk("R1 hold", int'(out_hold_o), 1);
    chk("R1 pga", int'(pga_o), 0);
    chk("R1 dac", int'(gain_dac_o), 32);
  endtask

  task automatic t_timeout();
    release_hold();
    raise_gain(3);
    chk("R9 step up", int'(pga_o), 3);
    repeat (WIN - 4) step();
    chk("R2 one edge short", int'(sys_rst_o), 0);
    step();
    chk("R2 fire", int'(sys_rst_o), 1);
    chk("R4 hold set", int'(out_hold_o), 1);
    chk("R4 pga preset", int'(pga_o), 0);
    chk("R4 dac preset", int'(gain_dac_o), 32);
    step();
    chk("R2 single pulse", int'(sys_rst_o), 0);
  endtask

  task automatic t_hold();
    int seen = 0;
    raise_gain(2);
    chk("R9 step while held", int'(pga_o), 2);
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0, 1'b0, 1'b0);
      if (sys_rst_o) seen++;
    end
    chk("R5 held edges ignored", int'(pga_o), 2);
    for (int i = 0; i < WIN + 16; i++) begin
      step();
      if (sys_rst_o) seen++;
    end
    chk("R5 no timeout while held", seen, 0);
    chk("R5 still held", int'(out_hold_o), 1);
    release_hold();
  endtask

  task automatic t_reload();
    repeat (40) step();
    pulse(1'b0, 1'b0, 1'b0);
    repeat (WIN - 2) step();
    chk("R3 reloaded window short", int'(sys_rst_o), 0);
    step();
    chk("R3 reloaded window fire", int'(sys_rst_o), 1);
    release_hold();
  endtask

  task automatic t_backoff();
    int seen = 0;
    raise_gain(2);
    for (int i = 0; i < 15; i++) pulse(1'b0, 1'b0, 1'b0);
    chk("R6 15 peakless", int'(pga_o), 2);
    pulse(1'b0, 1'b0, 1'b0);
    chk("R6 16th peakless", int'(pga_o), 1);
    chk("R10 dac untouched", int'(gain_dac_o), 32);
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0, 1'b0, 1'b0);
      if (sys_rst_o) seen++;
    end
    chk("R6 second backoff", int'(pga_o), 0);
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0, 1'b0, 1'b0);
      if (sys_rst_o) seen++;
    end
    chk("R8 saturate at zero", int'(pga_o), 0);
    chk("R10 no reset from backoff", seen, 0);
  endtask

  task automatic t_peak();
    raise_gain(1);
    for (int i = 0; i < 10; i++) pulse(1'b0, 1'b0, 1'b0);
    peak_min_i = 1'b1; step(); peak_min_i = 1'b0;
    for (int i = 0; i < 15; i++) pulse(1'b0, 1'b0, 1'b0);
    chk("R7 lone peak cleared count", int'(pga_o), 1);
    pulse(1'b0, 1'b0, 1'b0);
    chk("R7 backoff after clear", int'(pga_o), 0);
    raise_gain(1);
    for (int i = 0; i < 10; i++) pulse(1'b0, 1'b0, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 15; i++) pulse(1'b0, 1'b0, 1'b0);
    chk("R7 edge with peak cleared count", int'(pga_o), 1);
  endtask

  task automatic t_prio();
    pulse(1'b0, 1'b0, 1'b1);
    chk("R9 dec beats step", int'(pga_o), 0);
    raise_gain(20);
    chk("R9 step saturates", int'(pga_o), 15);
    pulse(1'b0, 1'b0, 1'b0);
    chk("R10 no reset", int'(sys_rst_o), 0);
  endtask

  initial begin
    step();
    t_reset();
    t_timeout();
    t_hold();
    t_reload();
    t_backoff();
    t_peak();
    t_prio();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule